// File: doc/BRIEF.md
# Bidirectional Pass-Through Port Bridge

This block joins a 10-bit converter data port to the upper ten lines of a 15-bit reference-DAC data port. A board can then reach either bus through the other. The bridge runs in either direction. When the bridge is off, the converter port carries the most recent conversion result, as it does in normal operation. When the bridge is on, a direction input picks which port is the source and which port is driven.

The pad side of each port uses separate input, output and output-enable lines. A tri-state pad outside the block merges them. Every switch between the three drive modes passes through a release interval in which neither output enable is asserted. This keeps the two drivers from fighting on a shared wire. The interval length is a parameter counted in clock cycles and stands in for the nanosecond turnaround of a real pad.

During pass-through the three active-low channel strobes must stay high. The block flags any strobe that falls while the bridge is requested.

Top module: `pt_port_bridge`

## Requirements
- R1: While reset is held and after it is released, the converter side is enabled and outputs `conv_result`, the DAC side enable is low, and `proto_err` is low.
- R2: With `bridge_en` low the converter side keeps outputting `conv_result`. Toggling `dir_to_cnv` while `bridge_en` is low changes neither output enable and starts no release interval.
- R3: With `bridge_en` high and `dir_to_cnv` high (the DAC port is the source), once the release interval ends `cnv_pad_oe` is 1 and `cnv_pad_out[i]` equals `dac_pad_in[i+5]` for i = 0..9.
- R4: With `bridge_en` high and `dir_to_cnv` low (the converter port is the source), once the release interval ends `dac_pad_oe` is 1, `dac_pad_out[i+5]` equals `cnv_pad_in[i]` for i = 0..9, and `dac_pad_out[4:0]` is 0.
- R5: `cnv_pad_oe` and `dac_pad_oe` are never both high. Neither rises in the cycle right after the other was high.
- R6: A change of the requested mode sampled at a clock edge drops both enables from the next cycle for exactly TURN_CYC cycles. The enable of the new mode rises after the TURN_CYC-th following edge. Leaving pass-through counts as a change of mode and returns the drive to `conv_result`.
- R7: If the request changes again during a release interval, the interval starts over from the latest change and ends in the latest requested mode.
- R8: `proto_err` is high for the cycle after each edge at which `bridge_en` is high and any bit of `strobe_n` is low. It is low after every other edge, including edges where a strobe is low while `bridge_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bridge_en | input | 1 | Pass-through request |
| dir_to_cnv | input | 1 | 1: DAC port drives converter port; 0: the reverse |
| strobe_n | input | 3 | Active-low channel strobes, monitored only |
| conv_result | input | 10 | Most recent conversion result |
| cnv_pad_in | input | 10 | Value seen on the converter pads |
| cnv_pad_out | output | 10 | Value driven onto the converter pads |
| cnv_pad_oe | output | 1 | Converter pad output enable |
| dac_pad_in | input | 15 | Value seen on the DAC data pads |
| dac_pad_out | output | 15 | Value driven onto the DAC data pads |
| dac_pad_oe | output | 1 | DAC pad output enable (upper ten lines) |
| proto_err | output | 1 | Strobe fell while pass-through requested |

## Verification
The bench changes the requested mode in every order: idle to each direction, straight reversal, and back to idle. At each change it counts the cycles in which both enables stay low. A design that skipped or shortened the release interval would show one enable rising too early or overlapping the other. A design that treated a direction toggle as a change while the bridge was off would drop the converter drive.

The bench also changes the request in the middle of a release interval. A design that kept the first countdown would enable the new side too soon. A design that latched the first target would enable the wrong side.

The data patterns place distinct values on every lane. A mapping that was off by one position, or that left the five lower DAC lines floating with stale data, would mismatch on those lanes.

The bench also lowers a strobe with the bridge off. A design that watched the strobes without qualifying them by the bridge request would raise a false error.

// File: rtl/pt_bridge_pkg.sv
package pt_bridge_pkg;

  typedef enum logic [1:0] {
    PM_NORM = 2'd0,
    PM_C2D  = 2'd1,
    PM_D2C  = 2'd2,
    PM_TURN = 2'd3
  } pt_mode_e;

  // Requested drive mode from the two control inputs.
  function automatic pt_mode_e pt_req_mode(input logic en, input logic to_cnv);
    if (!en) return PM_NORM;
    return to_cnv ? PM_D2C : PM_C2D;
  endfunction

  // DAC lane that pairs with converter lane cbit.
  function automatic int unsigned pt_dac_lane(input int unsigned cbit,
                                              input int unsigned shift);
    return cbit + shift;
  endfunction

endpackage

// File: rtl/pt_turn_ctrl.sv
module pt_turn_ctrl
  import pt_bridge_pkg::*;
#(
  parameter int unsigned TURN_CYC = 4,
  localparam int unsigned TCNT_W = (TURN_CYC < 2) ? 1 : $clog2(TURN_CYC)
) (
  input  logic     clk,
  input  logic     rst_n,
  input  pt_mode_e mode_req,
  output pt_mode_e mode_cur,
  output logic     turn_busy
);

  pt_mode_e          tgt_q;
  logic [TCNT_W-1:0] tcnt_q;

  localparam logic [TCNT_W-1:0] TLOAD = TCNT_W'(TURN_CYC - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_cur <= PM_NORM;
      tgt_q    <= PM_NORM;
      tcnt_q   <= '0;
    end else if (mode_cur != PM_TURN) begin
      if (mode_req != mode_cur) begin
        mode_cur <= PM_TURN;
        tgt_q    <= mode_req;
        tcnt_q   <= TLOAD;
      end
    end else begin
      if (mode_req != tgt_q) begin
        tgt_q  <= mode_req;
        tcnt_q <= TLOAD;
      end else if (tcnt_q == '0) begin
        mode_cur <= tgt_q;
      end else begin
        tcnt_q <= tcnt_q - 1'b1;
      end
    end
  end

  assign turn_busy = (mode_cur == PM_TURN);

endmodule

// File: rtl/pt_lane_map.sv
module pt_lane_map
  import pt_bridge_pkg::*;
#(
  parameter int unsigned CNV_W = 10,
  parameter int unsigned DAC_W = 15,
  localparam int unsigned SHIFT = DAC_W - CNV_W
) (
  input  pt_mode_e         mode_cur,
  input  logic [CNV_W-1:0] conv_result,
  input  logic [CNV_W-1:0] cnv_pad_in,
  input  logic [DAC_W-1:0] dac_pad_in,
  output logic [CNV_W-1:0] cnv_pad_out,
  output logic [DAC_W-1:0] dac_pad_out
);

  logic sel_dac_src;
  assign sel_dac_src = (mode_cur == PM_D2C);

  for (genvar i = 0; i < CNV_W; i++) begin : g_cnv_lane
    localparam int unsigned DL = pt_dac_lane(i, SHIFT);
    assign cnv_pad_out[i] = sel_dac_src ? dac_pad_in[DL] : conv_result[i];
  end

  for (genvar j = 0; j < DAC_W; j++) begin : g_dac_lane
    if (j < SHIFT) begin : g_low
      assign dac_pad_out[j] = 1'b0;
    end else begin : g_high
      assign dac_pad_out[j] = cnv_pad_in[j - SHIFT];
    end
  end

endmodule

// File: rtl/pt_strobe_mon.sv
module pt_strobe_mon #(
  parameter int unsigned NUM_STB = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bridge_en,
  input  logic [NUM_STB-1:0] strobe_n,
  output logic               proto_err
);

  logic stb_low;
  assign stb_low = ~&strobe_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) proto_err <= 1'b0;
    else        proto_err <= bridge_en & stb_low;
  end

endmodule

// File: rtl/pt_port_bridge.sv
module pt_port_bridge
  import pt_bridge_pkg::*;
#(
  parameter int unsigned CNV_W    = 10,
  parameter int unsigned DAC_W    = 15,
  parameter int unsigned NUM_STB  = 3,
  parameter int unsigned TURN_CYC = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bridge_en,
  input  logic               dir_to_cnv,
  input  logic [NUM_STB-1:0] strobe_n,
  input  logic [CNV_W-1:0]   conv_result,
  input  logic [CNV_W-1:0]   cnv_pad_in,
  output logic [CNV_W-1:0]   cnv_pad_out,
  output logic               cnv_pad_oe,
  input  logic [DAC_W-1:0]   dac_pad_in,
  output logic [DAC_W-1:0]   dac_pad_out,
  output logic               dac_pad_oe,
  output logic               proto_err
);

  pt_mode_e mode_req;
  pt_mode_e mode_cur;
  logic     turn_busy;

  assign mode_req = pt_req_mode(bridge_en, dir_to_cnv);

  pt_turn_ctrl #(.TURN_CYC(TURN_CYC)) u_turn (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_req  (mode_req),
    .mode_cur  (mode_cur),
    .turn_busy (turn_busy)
  );

  pt_lane_map #(.CNV_W(CNV_W), .DAC_W(DAC_W)) u_map (
    .mode_cur    (mode_cur),
    .conv_result (conv_result),
    .cnv_pad_in  (cnv_pad_in),
    .dac_pad_in  (dac_pad_in),
    .cnv_pad_out (cnv_pad_out),
    .dac_pad_out (dac_pad_out)
  );

  pt_strobe_mon #(.NUM_STB(NUM_STB)) u_stb (
    .clk       (clk),
    .rst_n     (rst_n),
    .bridge_en (bridge_en),
    .strobe_n  (strobe_n),
    .proto_err (proto_err)
  );

  assign cnv_pad_oe = (mode_cur == PM_NORM) || (mode_cur == PM_D2C);
  assign dac_pad_oe = (mode_cur == PM_C2D);

endmodule

// File: rtl/pt_port_bridge_chk.sv
module pt_port_bridge_chk
  import pt_bridge_pkg::*;
#(
  parameter int unsigned CNV_W    = 10,
  parameter int unsigned DAC_W    = 15,
  parameter int unsigned NUM_STB  = 3,
  parameter int unsigned TURN_CYC = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               bridge_en,
  input logic               dir_to_cnv,
  input logic [NUM_STB-1:0] strobe_n,
  input logic [CNV_W-1:0]   cnv_pad_in,
  input logic [DAC_W-1:0]   dac_pad_out,
  input logic               cnv_pad_oe,
  input logic               dac_pad_oe,
  input logic               proto_err,
  input logic               turn_busy
);

  localparam int unsigned GW = $clog2(TURN_CYC + 1) + 1;
  logic [GW-1:0] gap_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        gap_cnt <= '0;
    else if (cnv_pad_oe || dac_pad_oe) gap_cnt <= '0;
    else if (gap_cnt < GW'(TURN_CYC))  gap_cnt <= gap_cnt + 1'b1;
  end

  a_r5_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(cnv_pad_oe && dac_pad_oe));

  a_r5_dac_release: assert property (@(posedge clk) disable iff (!rst_n)
    dac_pad_oe |=> !cnv_pad_oe);

  a_r5_cnv_release: assert property (@(posedge clk) disable iff (!rst_n)
    cnv_pad_oe && !dac_pad_oe |=> !dac_pad_oe || $past(dac_pad_oe));

  a_r6_gap_length: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(cnv_pad_oe) || $rose(dac_pad_oe)) |-> gap_cnt >= GW'(TURN_CYC));

  a_r6_gap_idle: assert property (@(posedge clk) disable iff (!rst_n)
    turn_busy |-> !cnv_pad_oe && !dac_pad_oe);

  a_r4_dir_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dac_pad_oe) |-> $past(bridge_en) && !$past(dir_to_cnv));

  a_r4_lane_shift: assert property (@(posedge clk) disable iff (!rst_n)
    dac_pad_oe |-> dac_pad_out[DAC_W-1 -: CNV_W] == cnv_pad_in);

  a_r8_err_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (bridge_en && !(&strobe_n)) |=> proto_err);

  a_r8_no_false_err: assert property (@(posedge clk) disable iff (!rst_n)
    !bridge_en |=> !proto_err);

endmodule

bind pt_port_bridge pt_port_bridge_chk #(
  .CNV_W(CNV_W), .DAC_W(DAC_W), .NUM_STB(NUM_STB), .TURN_CYC(TURN_CYC)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bridge_en  (bridge_en),
  .dir_to_cnv (dir_to_cnv),
  .strobe_n   (strobe_n),
  .cnv_pad_in (cnv_pad_in),
  .dac_pad_out(dac_pad_out),
  .cnv_pad_oe (cnv_pad_oe),
  .dac_pad_oe (dac_pad_oe),
  .proto_err  (proto_err),
  .turn_busy  (turn_busy)
);

// File: tb/pt_port_bridge_tb.sv
module pt_port_bridge_tb;

  localparam int CNV_W = 10;
  localparam int DAC_W = 15;
  localparam int NSTB  = 3;
  localparam int TC    = 4;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             bridge_en = 1'b0;
  logic             dir_to_cnv = 1'b0;
  logic [NSTB-1:0]  strobe_n = '1;
  logic [CNV_W-1:0] conv_result = '0;
  logic [CNV_W-1:0] cnv_pad_in = '0;
  logic [CNV_W-1:0] cnv_pad_out;
  logic             cnv_pad_oe;
  logic [DAC_W-1:0] dac_pad_in = '0;
  logic [DAC_W-1:0] dac_pad_out;
  logic             dac_pad_oe;
  logic             proto_err;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  pt_port_bridge #(.CNV_W(CNV_W), .DAC_W(DAC_W), .NUM_STB(NSTB), .TURN_CYC(TC)) u_dut (
    .clk(clk), .rst_n(rst_n), .bridge_en(bridge_en), .dir_to_cnv(dir_to_cnv),
    .strobe_n(strobe_n), .conv_result(conv_result), .cnv_pad_in(cnv_pad_in),
    .cnv_pad_out(cnv_pad_out), .cnv_pad_oe(cnv_pad_oe), .dac_pad_in(dac_pad_in),
    .dac_pad_out(dac_pad_out), .dac_pad_oe(dac_pad_oe), .proto_err(proto_err)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk); @(negedge clk);
  endtask

  // Both enables low for TC cycles after the change, then the given pair.
  task automatic expect_turn(input string req, input logic c_oe, input logic d_oe);
    for (int k = 0; k < TC; k++) begin
      cyc();
      chk(req, {cnv_pad_oe, dac_pad_oe}, 2'b00);
    end
    cyc();
    chk(req, {cnv_pad_oe, dac_pad_oe}, {c_oe, d_oe});
  endtask

  task automatic t_reset();
    conv_result = 10'h2A5;
    #1;
    chk("R1 oe in reset", {cnv_pad_oe, dac_pad_oe}, 2'b10);
    @(negedge clk); rst_n = 1'b1;
    cyc();
    chk("R1 oe", {cnv_pad_oe, dac_pad_oe}, 2'b10);
    chk("R1 data", cnv_pad_out, 10'h2A5);
    chk("R1 err", proto_err, 1'b0);
  endtask

  task automatic t_idle_dir();
    for (int k = 0; k < 3; k++) begin
      dir_to_cnv = ~dir_to_cnv;
      conv_result = 10'h155 ^ 10'(k * 37);
      cyc();
      chk("R2 oe steady", {cnv_pad_oe, dac_pad_oe}, 2'b10);
      chk("R2 data", cnv_pad_out, 10'h155 ^ 10'(k * 37));
    end
  endtask

  task automatic t_d2c();
    dac_pad_in = 15'h5A3C;
    bridge_en = 1'b1; dir_to_cnv = 1'b1;
    expect_turn("R6 idle->d2c", 1'b1, 1'b0);
    chk("R3 map a", cnv_pad_out, 10'(15'h5A3C >> 5));
    dac_pad_in = 15'h03FF;
    #1;
    chk("R3 map b", cnv_pad_out, 10'(15'h03FF >> 5));
  endtask

  task automatic t_c2d();
    cnv_pad_in = 10'h3A1;
    dir_to_cnv = 1'b0;
    expect_turn("R6 d2c->c2d", 1'b0, 1'b1);
    chk("R4 map a", dac_pad_out, {10'h3A1, 5'b0});
    cnv_pad_in = 10'h05E;
    #1;
    chk("R4 map b", dac_pad_out, {10'h05E, 5'b0});
  endtask

  task automatic t_restart();
    bridge_en = 1'b0;
    cyc(); cyc();
    chk("R7 mid gap", {cnv_pad_oe, dac_pad_oe}, 2'b00);
    bridge_en = 1'b1; dir_to_cnv = 1'b1;
    dac_pad_in = 15'h7FE0;
    for (int k = 0; k < TC - 1; k++) cyc();
    chk("R7 still off", {cnv_pad_oe, dac_pad_oe}, 2'b00);
    cyc(); cyc();
    chk("R7 new side", {cnv_pad_oe, dac_pad_oe}, 2'b10);
    chk("R7 data", cnv_pad_out, 10'h3FF);
  endtask

  task automatic t_back_norm();
    conv_result = 10'h0C3;
    bridge_en = 1'b0;
    expect_turn("R6 exit", 1'b1, 1'b0);
    chk("R6 norm data", cnv_pad_out, 10'h0C3);
  endtask

  task automatic t_err();
    strobe_n = 3'b011;
    cyc();
    chk("R8 off no err", proto_err, 1'b0);
    strobe_n = '1;
    bridge_en = 1'b1; dir_to_cnv = 1'b0;
    cyc();
    chk("R8 clean", proto_err, 1'b0);
    strobe_n = 3'b101;
    cyc();
    chk("R8 err", proto_err, 1'b1);
    strobe_n = '1;
    cyc();
    chk("R8 clear", proto_err, 1'b0);
  endtask

  initial begin
    t_reset();
    t_idle_dir();
    t_d2c();
    t_c2d();
    t_restart();
    t_back_norm();
    t_err();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule